// File: doc/BRIEF.md
# Streaming TLP Header and Payload Separator

This block sits on a 256-bit packet stream of PCIe-style transaction layer packets, eight dwords per beat, with start and end markers, a valid/ready handshake and a two-bit empty count on the end beat. For every packet it emits one header record on a dedicated valid/ready port. It also produces a payload stream whose first data dword always sits in lane 0, packed with no gaps, with a dword-enable vector and a last flag on every beat.

A packet always starts in dword 0 of its first beat, and at most one packet is on the bus in any cycle. The header is three or four dwords long. Depending on the header size and on address bit 2, a filler dword may sit between the header and the first data dword. The block decodes the layout from the start beat and applies one dword rotation to the whole packet. Dwords left over from one input beat are held in a residue register until the next beat arrives. When the end beat leaves more dwords than one output beat can carry, the input is stalled for one cycle so that the extra beat can be sent.

Top module: `tlp_hdr_payload_split`

## Requirements
- R1: Header dword 0 bit 29 set means a 4-dword header and bit 30 set means a payload follows. The header record carries dwords 0 to 2, plus dword 3 in bits 127:96 for a 4-dword header (zero for a 3-dword header), and `hdr_four` reflects bit 29.
- R2: Address bit 2 is read from header dword 2 (3-dword header) or dword 3 (4-dword header). The first data dword sits at start-beat dword 4 when the 3-dword header has bit 2 clear, dword 3 when set, and for a 4-dword header at dword 4 when clear and dword 5 when set.
- R3: Payload dwords leave in arrival order, packed from lane 0 (bits 31:0) upward, eight per beat, and every beat except the last has all eight enables set.
- R4: On the end beat, the low 8 − 2·empty dwords are valid. The payload runs from the first data dword through the last valid dword. The final output beat sets the low n enable bits for its n dwords, and only that beat carries `pl_last`.
- R5: A packet whose start and end share one beat yields one header record and, if it has data, exactly one payload beat with `pl_last` set.
- R6: A packet without payload (bit 30 clear, single beat) yields a header record and no payload beat.
- R7: When the end beat leaves more than eight pending dwords, `in_ready` is low in the cycle after that beat is taken, and one extra payload beat follows.
- R8: No payload beat of a packet is offered before that packet's header record has been accepted.
- R9: Under backpressure on either output, the offered data stays stable, and no header or payload dword is lost or repeated.
- R10: After a synchronous reset, both output valids are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 256 | Input beat, dword k at bits 32k+31:32k |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_valid | input | 1 | Input beat present |
| in_empty | input | 2 | Unused 64-bit units at the top of the end beat |
| in_ready | output | 1 | Block can take an input beat |
| hdr_valid | output | 1 | Header record present |
| hdr_ready | input | 1 | Header consumer accepts |
| hdr_data | output | 128 | Header dwords 0..3 |
| hdr_four | output | 1 | Header is four dwords long |
| pl_valid | output | 1 | Payload beat present |
| pl_ready | input | 1 | Payload consumer accepts |
| pl_data | output | 256 | Packed payload dwords |
| pl_dwen | output | 8 | Per-lane dword enables |
| pl_last | output | 1 | Final payload beat of the packet |

## Verification
A header record appears one clock after its start beat is taken. A payload beat appears one clock after the input beat that completes it, and an overflow tail beat appears one clock after the overflowing end beat. The bench drives inputs at the falling edge and lets the combinational `in_ready` settle. It then records the handshakes that the coming rising edge will complete, so each result is compared against the behavioural model exactly at its handshake and never at a fixed latency. The stall of R7 is checked in the first sampling window after the overflowing beat is taken.

// File: rtl/tlp_split_pkg.sv
`timescale 1ns/1ps
package tlp_split_pkg;

  // Start-beat layout: header size, payload presence, filler dword before data.
  typedef struct packed {
    logic four;
    logic has_data;
    logic pad;
  } layout_t;

endpackage

// File: rtl/tlp_layout_decode.sv
`timescale 1ns/1ps
module tlp_layout_decode
  import tlp_split_pkg::*;
(
  input  logic    fmt_four,
  input  logic    fmt_data,
  input  logic    addr_3dw,
  input  logic    addr_4dw,
  output layout_t lay
);

  logic addr_bit;

  assign addr_bit     = fmt_four ? addr_4dw : addr_3dw;
  assign lay.four     = fmt_four;
  assign lay.has_data = fmt_data;
  // Filler needed when data parity differs from the slot following the header.
  assign lay.pad      = ~(fmt_four ^ addr_bit);

endmodule

// File: rtl/tlp_dword_merge.sv
`timescale 1ns/1ps
module tlp_dword_merge #(
  parameter int DW_W    = 32,
  parameter int BEAT_DW = 8
) (
  input  logic [DW_W*BEAT_DW-1:0]     lo_beat,
  input  logic [DW_W*BEAT_DW-1:0]     hi_beat,
  input  logic [$clog2(BEAT_DW):0]    shift,
  output logic [DW_W*BEAT_DW-1:0]     merged
);

  localparam int LOG_W = $clog2(BEAT_DW);
  localparam int IDX_W = LOG_W + 1;

  for (genvar i = 0; i < BEAT_DW; i++) begin : g_lane
    logic [IDX_W-1:0] src;
    assign src = IDX_W'(i) + shift;
    assign merged[i*DW_W +: DW_W] = src[LOG_W] ? hi_beat[src[LOG_W-1:0]*DW_W +: DW_W]
                                               : lo_beat[src[LOG_W-1:0]*DW_W +: DW_W];
  end

endmodule

// File: rtl/tlp_lane_mask.sv
`timescale 1ns/1ps
module tlp_lane_mask #(
  parameter int BEAT_DW = 8
) (
  input  logic [$clog2(BEAT_DW):0] count,
  output logic [BEAT_DW-1:0]       mask
);

  localparam int CNT_W = $clog2(BEAT_DW) + 1;

  for (genvar i = 0; i < BEAT_DW; i++) begin : g_bit
    assign mask[i] = CNT_W'(i) < count;
  end

endmodule

// File: rtl/tlp_hdr_payload_split.sv
`timescale 1ns/1ps
module tlp_hdr_payload_split
  import tlp_split_pkg::*;
#(
  parameter int DW_W      = 32,
  parameter int BEAT_DW   = 8,
  parameter int EMPTY_W   = 2,
  parameter int FOUR_BIT  = 29,
  parameter int DATA_BIT  = 30,
  parameter int ALIGN_BIT = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DW_W*BEAT_DW-1:0]  in_data,
  input  logic                     in_sop,
  input  logic                     in_eop,
  input  logic                     in_valid,
  input  logic [EMPTY_W-1:0]       in_empty,
  output logic                     in_ready,
  output logic                     hdr_valid,
  input  logic                     hdr_ready,
  output logic [4*DW_W-1:0]        hdr_data,
  output logic                     hdr_four,
  output logic                     pl_valid,
  input  logic                     pl_ready,
  output logic [DW_W*BEAT_DW-1:0]  pl_data,
  output logic [BEAT_DW-1:0]       pl_dwen,
  output logic                     pl_last
);

  localparam int BUS_W = DW_W * BEAT_DW;
  localparam int LOG_W = $clog2(BEAT_DW);
  localparam int CNT_W = LOG_W + 1;

  // Registered state
  logic              hdr_vq, hdr_four_q;
  logic [4*DW_W-1:0] hdr_data_q;
  logic              pl_vq, pl_last_q;
  logic [BUS_W-1:0]  pl_data_q;
  logic [BEAT_DW-1:0] pl_dwen_q;
  logic [BUS_W-1:0]  res_q;
  logic [CNT_W-1:0]  sh_q;
  logic              flush_q;
  logic [CNT_W-1:0]  flush_n_q;

  // Combinational
  layout_t           lay;
  logic [CNT_W-1:0]  hdr_off, in_cnt, emit_n, m_sh;
  logic [CNT_W:0]    avail;
  logic              overflow, acc, pl_fire, slot_free, hdr_free;
  logic              emit, emit_last, take_sop;
  logic [BUS_W-1:0]  m_lo, mrg;
  logic [BEAT_DW-1:0] mask;

  tlp_layout_decode u_dec (
    .fmt_four (in_data[FOUR_BIT]),
    .fmt_data (in_data[DATA_BIT]),
    .addr_3dw (in_data[2*DW_W+ALIGN_BIT]),
    .addr_4dw (in_data[3*DW_W+ALIGN_BIT]),
    .lay      (lay)
  );

  assign hdr_off = (lay.four ? CNT_W'(4) : CNT_W'(3)) + CNT_W'(lay.pad);
  assign in_cnt  = in_eop ? CNT_W'(BEAT_DW) - (CNT_W'(in_empty) << 1) : CNT_W'(BEAT_DW);
  assign avail   = {1'b0, CNT_W'(BEAT_DW) - sh_q} + {1'b0, in_cnt};
  assign overflow = avail > (CNT_W+1)'(BEAT_DW);

  // Handshakes: payload is gated until the header record has gone.
  assign pl_fire   = pl_vq & ~hdr_vq & pl_ready;
  assign slot_free = ~pl_vq | pl_fire;
  assign hdr_free  = ~hdr_vq | hdr_ready;
  assign in_ready  = ~flush_q & slot_free & hdr_free;
  assign acc       = in_valid & in_ready;

  assign take_sop = ~flush_q & in_sop;
  assign m_lo     = take_sop ? in_data : res_q;
  assign m_sh     = take_sop ? hdr_off : sh_q;

  tlp_dword_merge #(.DW_W(DW_W), .BEAT_DW(BEAT_DW)) u_merge (
    .lo_beat (m_lo),
    .hi_beat (in_data),
    .shift   (m_sh),
    .merged  (mrg)
  );

  tlp_lane_mask #(.BEAT_DW(BEAT_DW)) u_mask (
    .count (emit_n),
    .mask  (mask)
  );

  always_comb begin
    emit      = 1'b0;
    emit_last = 1'b0;
    emit_n    = CNT_W'(BEAT_DW);
    if (flush_q) begin
      emit      = slot_free;
      emit_last = 1'b1;
      emit_n    = flush_n_q;
    end else if (acc) begin
      if (in_sop) begin
        emit      = lay.has_data & in_eop;
        emit_last = 1'b1;
        emit_n    = in_cnt - hdr_off;
      end else begin
        emit = 1'b1;
        if (in_eop && !overflow) begin
          emit_last = 1'b1;
          emit_n    = CNT_W'(avail);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_vq  <= 1'b0;
      pl_vq   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      if (hdr_vq && hdr_ready) hdr_vq <= 1'b0;
      if (pl_fire)             pl_vq  <= 1'b0;
      if (emit) begin
        pl_vq     <= 1'b1;
        pl_data_q <= mrg;
        pl_dwen_q <= mask;
        pl_last_q <= emit_last;
      end
      if (flush_q) begin
        if (slot_free) flush_q <= 1'b0;
      end else if (acc) begin
        res_q <= in_data;
        if (in_sop) begin
          hdr_vq     <= 1'b1;
          hdr_four_q <= lay.four;
          hdr_data_q <= {lay.four ? in_data[4*DW_W-1:3*DW_W] : {DW_W{1'b0}},
                         in_data[3*DW_W-1:0]};
          sh_q       <= hdr_off;
        end else if (in_eop && overflow) begin
          flush_q   <= 1'b1;
          flush_n_q <= in_cnt - sh_q;
        end
      end
    end
  end

  assign hdr_valid = hdr_vq;
  assign hdr_data  = hdr_data_q;
  assign hdr_four  = hdr_four_q;
  assign pl_valid  = pl_vq & ~hdr_vq;
  assign pl_data   = pl_data_q;
  assign pl_dwen   = pl_dwen_q;
  assign pl_last   = pl_last_q;

  // R7: an overflowing end beat stalls the input for the tail beat
  a_r7_tail_stall: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_sop && in_eop && overflow) |=> !in_ready);

  // R9: payload beat held while refused
  a_r9_pl_hold: assert property (@(posedge clk) disable iff (rst)
    (pl_valid && !pl_ready) |=> (pl_valid && $stable(pl_data) && $stable(pl_dwen) && $stable(pl_last)));

  // R9: header record held while refused
  a_r9_hdr_hold: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr_data) && $stable(hdr_four)));

  // R3: non-final beats are full
  a_r3_full_beat: assert property (@(posedge clk) disable iff (rst)
    (pl_valid && !pl_last) |-> (&pl_dwen));

  // R4: enables form a contiguous run from lane 0
  a_r4_contig_en: assert property (@(posedge clk) disable iff (rst)
    pl_valid |-> (pl_dwen[0] && ((pl_dwen & (pl_dwen + BEAT_DW'(1))) == '0)));

endmodule

// File: tb/tlp_hdr_payload_split_bench.sv
`timescale 1ns/1ps
module tlp_hdr_payload_split_bench;

  localparam int DW_W    = 32;
  localparam int BEAT_DW = 8;
  localparam int BUS_W   = DW_W * BEAT_DW;
  localparam int LIMIT   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [BUS_W-1:0] in_data = '0;
  logic in_sop = 1'b0, in_eop = 1'b0, in_valid = 1'b0;
  logic [1:0] in_empty = '0;
  logic in_ready;
  logic hdr_valid, hdr_four;
  logic hdr_ready = 1'b0;
  logic [4*DW_W-1:0] hdr_data;
  logic pl_valid, pl_last;
  logic pl_ready = 1'b0;
  logic [BUS_W-1:0] pl_data;
  logic [BEAT_DW-1:0] pl_dwen;

  tlp_hdr_payload_split u_tlp_hdr_payload_split (
    .clk(clk), .rst(rst), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .in_valid(in_valid), .in_empty(in_empty), .in_ready(in_ready),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data), .hdr_four(hdr_four),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data), .pl_dwen(pl_dwen),
    .pl_last(pl_last)
  );

  always #2 clk = ~clk;

  // Stimulus queues
  logic [BUS_W-1:0] beat_q[$];
  bit sop_q[$], eop_q[$], ovf_q[$];
  logic [1:0] emp_q[$];
  // Expectation queues
  logic [4*DW_W-1:0] hexp_q[$];
  bit hfour_q[$];
  logic [BUS_W-1:0] pexp_q[$];
  logic [BEAT_DW-1:0] pen_q[$];
  bit plast_q[$];
  int ppkt_q[$];
  string ptag_q[$];

  int n_chk = 0, n_err = 0;
  int beat_i = 0, pid = 0, hdr_seen = 0, pl_seen = 0, pl_total = 0, cyc = 0;
  bit run = 0, rand_bp = 0, expect_stall = 0;
  string ph_tag = "";

  task automatic chk(bit ok, string tag, logic [BUS_W-1:0] act, logic [BUS_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic add_pkt(bit four, bit hasd, bit a, int len);
    logic [31:0] dw [0:47];
    int hl, pad, off, tot, nb, vl;
    logic [BUS_W-1:0] b;
    hl  = four ? 4 : 3;
    pad = (four == a) ? 1 : 0;
    off = hl + pad;
    tot = hasd ? off + len : 4;
    nb  = (tot + 7) / 8;
    vl  = tot - 8 * (nb - 1);
    for (int i = 0; i < 48; i++) dw[i] = $urandom;
    dw[0][31] = 1'b0;
    dw[0][30] = hasd;
    dw[0][29] = four;
    if (four) dw[3][2] = a; else dw[2][2] = a;
    for (int k = 0; k < len; k++) dw[off+k] = {pid[15:0], k[15:0]};
    for (int bi = 0; bi < nb; bi++) begin
      for (int i = 0; i < 8; i++) b[i*32 +: 32] = dw[bi*8+i];
      beat_q.push_back(b);
      sop_q.push_back(bi == 0);
      eop_q.push_back(bi == nb - 1);
      emp_q.push_back((bi == nb - 1) ? 2'((8 - vl) / 2) : 2'($urandom));
      ovf_q.push_back(bi == nb - 1 && bi > 0 && vl > off);
    end
    hexp_q.push_back({four ? dw[3] : 32'h0, dw[2], dw[1], dw[0]});
    hfour_q.push_back(four);
    if (hasd) begin
      for (int c = 0; c < (len + 7) / 8; c++) begin
        logic [BEAT_DW-1:0] en;
        b  = '0;
        en = '0;
        for (int j = 0; j < 8; j++)
          if (8*c + j < len) begin b[j*32 +: 32] = dw[off+8*c+j]; en[j] = 1'b1; end
        pexp_q.push_back(b);
        pen_q.push_back(en);
        plast_q.push_back(c == (len + 7) / 8 - 1);
        ppkt_q.push_back(pid);
        ptag_q.push_back(nb == 1 ? "R5" : (c == (len + 7) / 8 - 1) ? "R2 R4" : "R2 R3");
        pl_total++;
      end
    end
    pid++;
  endtask

  task automatic add_set();
    for (int f = 0; f < 2; f++)
      for (int a = 0; a < 2; a++) begin
        int off;
        off = (f ? 4 : 3) + ((f == a) ? 1 : 0);
        for (int len = 1; len <= 20; len++)
          if ((off + len) % 2 == 0) add_pkt(f[0], 1'b1, a[0], len);
        add_pkt(f[0], 1'b0, a[0], 0);
      end
  endtask

  always @(negedge clk) if (run) begin
    cyc++;
    if (beat_i < beat_q.size()) begin
      in_valid = rand_bp ? ($urandom % 4 != 0) : 1'b1;
      in_data  = beat_q[beat_i];
      in_sop   = sop_q[beat_i];
      in_eop   = eop_q[beat_i];
      in_empty = emp_q[beat_i];
    end else begin
      in_valid = 1'b0;
    end
    pl_ready  = rand_bp ? ($urandom % 3 != 0) : 1'b1;
    hdr_ready = rand_bp ? ($urandom % 3 != 0) : 1'b1;
    #1;
    if (expect_stall) begin
      chk(!in_ready, {"R7 stall after overflow", ph_tag}, BUS_W'(in_ready), '0);
      expect_stall = 0;
    end
    if (in_valid && in_ready) begin
      if (ovf_q[beat_i]) expect_stall = 1;
      beat_i++;
    end
    if (pl_valid && pl_ready) begin
      if (pexp_q.size() == 0) begin
        chk(0, {"R6 stray payload beat", ph_tag}, pl_data, '0);
      end else begin
        logic [BUS_W-1:0] e, m;
        logic [BEAT_DW-1:0] en;
        int p;
        string t;
        e = pexp_q.pop_front(); en = pen_q.pop_front(); p = ppkt_q.pop_front();
        t = ptag_q.pop_front();
        m = '0;
        for (int j = 0; j < 8; j++) if (en[j]) m[j*32 +: 32] = '1;
        chk((pl_data & m) == e, {t, " payload data", ph_tag}, pl_data & m, e);
        chk(pl_dwen == en, {"R4 dword enables", ph_tag}, BUS_W'(pl_dwen), BUS_W'(en));
        chk(pl_last == plast_q.pop_front(), {"R4 last flag", ph_tag}, BUS_W'(pl_last), BUS_W'(!pl_last));
        chk(p < hdr_seen, {"R8 header before payload", ph_tag}, BUS_W'(hdr_seen), BUS_W'(p + 1));
      end
      pl_seen++;
    end
    if (hdr_valid && hdr_ready) begin
      if (hexp_q.size() == 0) begin
        chk(0, {"R1 stray header", ph_tag}, BUS_W'(hdr_data), '0);
      end else begin
        logic [4*DW_W-1:0] he;
        bit hf;
        he = hexp_q.pop_front(); hf = hfour_q.pop_front();
        chk(hdr_data == he, {"R1 header record", ph_tag}, BUS_W'(hdr_data), BUS_W'(he));
        chk(hdr_four == hf, {"R1 header size flag", ph_tag}, BUS_W'(hdr_four), BUS_W'(hf));
      end
      hdr_seen++;
    end
  end

  task automatic drain();
    while ((beat_i < beat_q.size() || hexp_q.size() != 0 || pexp_q.size() != 0) && cyc < LIMIT)
      @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    #1;
    // R10: reset state
    chk(!hdr_valid && !pl_valid && in_ready, "R10 reset state",
        BUS_W'({hdr_valid, pl_valid, in_ready}), BUS_W'(3'b001));
    add_set();
    run = 1;
    drain();
    rand_bp = 1;
    ph_tag  = " R9";
    add_set();
    add_set();
    drain();
    run = 0;
    if (cyc >= LIMIT) chk(0, "watchdog expired", BUS_W'(cyc), BUS_W'(LIMIT));
    chk(hdr_seen == pid, "R1 R9 header count", BUS_W'(hdr_seen), BUS_W'(pid));
    chk(pl_seen == pl_total, "R6 R9 payload beat count", BUS_W'(pl_seen), BUS_W'(pl_total));
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule